// File: doc/BRIEF.md
# Cache Line State Resolver

This block picks the coherence state of a data-cache line in two situations: a cacheable read miss that fills the line, and a write that hits a line held shared. A line becomes exclusive only when the system answers the bus cycle with its writeback-permit input high and the page attribute does not force writethrough. Otherwise the line becomes shared, and every later write to it goes out on the bus. A write hit to an exclusive line promotes it to modified with no bus cycle. A write hit to a modified line leaves it modified.

Requests come in on a valid/ready stream. Each request carries the operation, the line's current state and the page-writethrough bit. Results leave on a second valid/ready stream. A request that needs no bus cycle produces its result at once. A request that depends on the system's answer waits until a matching bus cycle ends. The bus-cycle pins (start, kind, burst, ready, next-address, writeback-permit) are plain control inputs that follow the bus. The block accepts one request at a time: `req_ready` is low while a request waits or while a result is unaccepted. A result holds its value until `res_ready` takes it.

Top module: `lcs_resolver`

## Requirements
- R1: After reset, `res_valid` is 0 and `req_ready` is 1.
- R2: A fill (`req_op`=0) resolves at the end of a memory-read cycle (`bus_kind`=0). The state is exclusive (`res_state`=2'b10) when the sampled permit is 1 and `req_pwt` is 0. Otherwise it is shared (2'b01). `res_ext` is 0.
- R3: A write hit (`req_op`=1) to an exclusive (2'b10) or modified (2'b11) line gives modified (2'b11) with `res_ext`=0. It is valid on the edge that accepts the request.
- R4: A write hit to a shared (2'b01) line gives a result only when a memory-write cycle (`bus_kind`=1) ends. The result has `res_ext`=1, and its state follows the same rule as R2.
- R5: The permit input is sampled only on the first edge of a cycle on which `bus_rdy` or `bus_na` is high. Values on later beats have no effect.
- R6: Cycles of any other kind (2 writeback write, 3 I/O read, 4 I/O write, 5 interrupt acknowledge, 6 special) neither sample the permit nor complete a waiting request.
- R7: A cycle started with `bus_burst`=1 ends on the fourth `bus_rdy` (BEATS). A cycle started with `bus_burst`=0 ends on the first. A deferred result is valid on the edge after the last beat, and not before.
- R8: `req_ready` is 0 while a request waits or a result is held. While `res_valid` is 1 and `res_ready` is 0, the result does not change.
- R9: A write hit to an invalid (2'b00) line gives invalid with `res_ext`=1 at once.
- R10: `bus_start` while a cycle is active is ignored. The running cycle keeps its kind and beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | Pulse that opens a bus cycle |
| bus_kind | input | 3 | Kind of the cycle being opened |
| bus_burst | input | 1 | Opened cycle is a burst |
| bus_rdy | input | 1 | Beat-ready from the system |
| bus_na | input | 1 | Next-address request from the system |
| wbwt_in | input | 1 | Writeback permit from the system |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 1 | 0 fill, 1 write hit |
| req_cur | input | 2 | Current line state |
| req_pwt | input | 1 | Page-writethrough attribute |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result taken by consumer |
| res_state | output | 2 | Resolved line state |
| res_ext | output | 1 | The write must be issued on the bus |

## Verification
The bench changes the permit input after the first beat of a burst. A design that samples late, or on every beat, then reports the wrong state. It also asserts next-address before the first ready with an opposite permit value, which shows whether next-address is ignored as a sample point. Foreign cycles with the permit high run while a shared write waits; a design that lets them through resolves too early or to exclusive. A restart pulse in the middle of a burst, and a consumer that holds off, show whether the cycle is cut short or the held result drifts.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10,
    LS_MOD = 2'b11
  } line_st_e;

  typedef enum logic [2:0] {
    BK_MEM_RD  = 3'd0,
    BK_MEM_WR  = 3'd1,
    BK_MEM_WB  = 3'd2,
    BK_IO_RD   = 3'd3,
    BK_IO_WR   = 3'd4,
    BK_INTA    = 3'd5,
    BK_SPECIAL = 3'd6,
    BK_RSVD    = 3'd7
  } bus_kind_e;

  typedef enum logic {
    OP_FILL = 1'b0,
    OP_WHIT = 1'b1
  } req_op_e;

  typedef struct packed {
    line_st_e st;
    logic     ext;
  } line_res_t;
endpackage

// File: rtl/lcs_cycle_track.sv
module lcs_cycle_track
  import lcs_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  bus_kind_e kind_i,
  input  logic      burst_i,
  input  logic      rdy_i,
  input  logic      na_i,
  input  logic      wb_i,
  output logic      done_o,
  output bus_kind_e done_kind_o,
  output logic      wb_ok_o,
  output logic      wb_o
);
  localparam int CW = $clog2(BEATS + 1);
  localparam logic [CW-1:0] LEN_BURST  = CW'(BEATS);
  localparam logic [CW-1:0] LEN_SINGLE = CW'(1);

  logic          active_q;
  bus_kind_e     kind_q;
  logic [CW-1:0] left_q;
  logic          smp_q;
  logic          wb_q;

  logic first_now;
  logic qual;
  logic last_beat;

  assign qual      = (kind_q == BK_MEM_RD) || (kind_q == BK_MEM_WR);
  assign first_now = active_q && !smp_q && (rdy_i || na_i);
  assign last_beat = active_q && rdy_i && (left_q == LEN_SINGLE);

  assign done_o      = last_beat;
  assign done_kind_o = kind_q;
  assign wb_o        = first_now ? wb_i : wb_q;
  assign wb_ok_o     = qual && (smp_q || first_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      kind_q   <= BK_MEM_RD;
      left_q   <= '0;
      smp_q    <= 1'b0;
      wb_q     <= 1'b0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        kind_q   <= kind_i;
        left_q   <= burst_i ? LEN_BURST : LEN_SINGLE;
        smp_q    <= 1'b0;
      end
    end else begin
      if (first_now) begin
        smp_q <= 1'b1;
        if (qual) wb_q <= wb_i;
      end
      if (last_beat) begin
        active_q <= 1'b0;
        smp_q    <= 1'b0;
      end else if (rdy_i) begin
        left_q <= left_q - LEN_SINGLE;
      end
    end
  end

  // Sampling only happens on an edge with ready or next-address seen.
  assert_sample_point_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_q) |-> $past(rdy_i || na_i));

  // A cycle of a non-qualifying kind never loads the permit register.
  assert_foreign_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (first_now && !qual) |=> $stable(wb_q));

  // A start pulse during an active cycle leaves its kind untouched.
  assert_restart_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && start_i && !last_beat) |=> (active_q && $stable(kind_q)));

  // The cycle closes on its final ready.
  assert_cycle_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> !active_q);
endmodule

// File: rtl/lcs_state_rules.sv
module lcs_state_rules
  import lcs_pkg::*;
(
  input  req_op_e   op_i,
  input  line_st_e  cur_i,
  output logic      imm_o,
  output line_res_t imm_res_o,
  input  req_op_e   pend_op_i,
  input  logic      pend_pwt_i,
  input  logic      wb_i,
  output line_res_t def_res_o
);
  always_comb begin
    imm_o     = 1'b0;
    imm_res_o = '{st: LS_MOD, ext: 1'b0};
    if (op_i == OP_WHIT) begin
      unique case (cur_i)
        LS_INV: begin
          imm_o     = 1'b1;
          imm_res_o = '{st: LS_INV, ext: 1'b1};
        end
        LS_EXC, LS_MOD: begin
          imm_o     = 1'b1;
          imm_res_o = '{st: LS_MOD, ext: 1'b0};
        end
        default: imm_o = 1'b0;
      endcase
    end
  end

  always_comb begin
    def_res_o.st  = (wb_i && !pend_pwt_i) ? LS_EXC : LS_SHR;
    def_res_o.ext = (pend_op_i == OP_WHIT);
  end
endmodule

// File: rtl/lcs_res_slot.sv
module lcs_res_slot
  import lcs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_i,
  input  line_res_t data_i,
  input  logic      ready_i,
  output logic      valid_o,
  output line_res_t data_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '{st: LS_INV, ext: 1'b0};
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  // A held result stays put until the consumer takes it.
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/lcs_resolver.sv
module lcs_resolver
  import lcs_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_start,
  input  logic [2:0] bus_kind,
  input  logic       bus_burst,
  input  logic       bus_rdy,
  input  logic       bus_na,
  input  logic       wbwt_in,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_op,
  input  logic [1:0] req_cur,
  input  logic       req_pwt,
  output logic       res_valid,
  input  logic       res_ready,
  output logic [1:0] res_state,
  output logic       res_ext
);
  logic      done;
  bus_kind_e done_kind;
  logic      wb_ok;
  logic      wb_eff;

  logic      pend_q;
  req_op_e   pend_op_q;
  logic      pend_pwt_q;

  logic      imm;
  line_res_t imm_res;
  line_res_t def_res;
  line_res_t slot_out;
  logic      req_fire;
  logic      kind_match;
  logic      resolve;
  logic      load;
  line_res_t load_res;

  lcs_cycle_track #(.BEATS(BEATS)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (bus_start),
    .kind_i      (bus_kind_e'(bus_kind)),
    .burst_i     (bus_burst),
    .rdy_i       (bus_rdy),
    .na_i        (bus_na),
    .wb_i        (wbwt_in),
    .done_o      (done),
    .done_kind_o (done_kind),
    .wb_ok_o     (wb_ok),
    .wb_o        (wb_eff)
  );

  lcs_state_rules u_rules (
    .op_i       (req_op_e'(req_op)),
    .cur_i      (line_st_e'(req_cur)),
    .imm_o      (imm),
    .imm_res_o  (imm_res),
    .pend_op_i  (pend_op_q),
    .pend_pwt_i (pend_pwt_q),
    .wb_i       (wb_eff),
    .def_res_o  (def_res)
  );

  assign req_ready  = !pend_q && !res_valid;
  assign req_fire   = req_valid && req_ready;
  assign kind_match = (pend_op_q == OP_FILL) ? (done_kind == BK_MEM_RD)
                                             : (done_kind == BK_MEM_WR);
  assign resolve    = pend_q && done && wb_ok && kind_match;
  assign load       = resolve || (req_fire && imm);
  assign load_res   = resolve ? def_res : imm_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_op_q  <= OP_FILL;
      pend_pwt_q <= 1'b0;
    end else if (req_fire && !imm) begin
      pend_q     <= 1'b1;
      pend_op_q  <= req_op_e'(req_op);
      pend_pwt_q <= req_pwt;
    end else if (resolve) begin
      pend_q <= 1'b0;
    end
  end

  lcs_res_slot u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .data_i  (load_res),
    .ready_i (res_ready),
    .valid_o (res_valid),
    .data_o  (slot_out)
  );

  assign res_state = slot_out.st;
  assign res_ext   = slot_out.ext;

  // A write hit on an owned line yields modified on the next edge.
  assert_excl_promote_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_op && req_cur[1]) |=> (res_valid && res_state == 2'b11 && !res_ext));

  // Waiting request and held result never coexist.
  assert_single_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !pend_q);

  // A deferred write-hit result always demands a bus write.
  assert_shared_write_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve && pend_op_q == OP_WHIT) |=> (res_valid && res_ext));
endmodule

// File: tb/tb_lcs_resolver.sv
module tb_lcs_resolver;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_start = 1'b0;
  logic [2:0] bus_kind = 3'd0;
  logic       bus_burst = 1'b0;
  logic       bus_rdy = 1'b0;
  logic       bus_na = 1'b0;
  logic       wbwt_in = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_op = 1'b0;
  logic [1:0] req_cur = 2'b00;
  logic       req_pwt = 1'b0;
  logic       res_valid;
  logic       res_ready = 1'b1;
  logic [1:0] res_state;
  logic       res_ext;

  int n_chk = 0;
  int n_bad = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  lcs_resolver dut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_kind(bus_kind),
    .bus_burst(bus_burst), .bus_rdy(bus_rdy), .bus_na(bus_na), .wbwt_in(wbwt_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_cur(req_cur),
    .req_pwt(req_pwt), .res_valid(res_valid), .res_ready(res_ready),
    .res_state(res_state), .res_ext(res_ext)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_res(input logic [1:0] st, input logic ext, input string tag);
    exp_q.push_back({st, ext});
    tag_q.push_back(tag);
  endtask

  // Monitor: pops a result whenever a handshake is about to occur.
  always begin
    @(negedge clk);
    #(PERIOD/4);
    if (rst_n && res_valid && res_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected result", int'({res_state, res_ext}), -1);
      end else begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({res_state, res_ext} == e, t, int'({res_state, res_ext}), int'(e));
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic start_cyc(input logic [2:0] k, input logic b);
    bus_start = 1'b1; bus_kind = k; bus_burst = b;
    tick();
    bus_start = 1'b0;
  endtask

  task automatic beat(input logic r, input logic n, input logic w);
    bus_rdy = r; bus_na = n; wbwt_in = w;
    tick();
    bus_rdy = 1'b0; bus_na = 1'b0;
  endtask

  task automatic send(input logic op, input logic [1:0] cur, input logic pwt);
    req_valid = 1'b1; req_op = op; req_cur = cur; req_pwt = pwt;
    while (!req_ready) tick();
    tick();
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    check(res_valid == 1'b0, "R1 res_valid", int'(res_valid), 0);

    // R2 R5 R7: burst fill, permit 1 on first beat then toggled
    expect_res(2'b10, 1'b0, "R2 R5 fill exclusive");
    send(1'b0, 2'b00, 1'b0);
    start_cyc(3'd0, 1'b1);
    beat(1, 0, 1); beat(1, 0, 0); beat(1, 0, 0);
    check(res_valid == 1'b0, "R7 early result", int'(res_valid), 0);
    beat(1, 0, 0);
    check(res_valid == 1'b1, "R7 result after last beat", int'(res_valid), 1);
    tick();

    // R5: permit 0 first, 1 later -> shared
    expect_res(2'b01, 1'b0, "R5 late permit ignored");
    send(1'b0, 2'b00, 1'b0);
    start_cyc(3'd0, 1'b1);
    beat(1, 0, 0); beat(1, 0, 1); beat(1, 0, 1); beat(1, 0, 1);
    tick();

    // R2: page writethrough forces shared
    expect_res(2'b01, 1'b0, "R2 pwt forces shared");
    send(1'b0, 2'b00, 1'b1);
    start_cyc(3'd0, 1'b1);
    beat(1, 0, 1); beat(1, 0, 1); beat(1, 0, 1); beat(1, 0, 1);
    tick();

    // R5: next-address is the first sample point
    expect_res(2'b10, 1'b0, "R5 sample on next-address");
    send(1'b0, 2'b00, 1'b0);
    start_cyc(3'd0, 1'b1);
    beat(0, 1, 1); beat(1, 0, 0); beat(1, 0, 0); beat(1, 0, 0); beat(1, 0, 0);
    tick();

    // R3: write hits to exclusive and modified
    expect_res(2'b11, 1'b0, "R3 exclusive to modified");
    send(1'b1, 2'b10, 1'b0);
    check(res_valid == 1'b1, "R3 immediate", int'(res_valid), 1);
    tick();
    expect_res(2'b11, 1'b0, "R3 modified stays");
    send(1'b1, 2'b11, 1'b1);
    tick();

    // R9: write hit to invalid
    expect_res(2'b00, 1'b1, "R9 invalid write");
    send(1'b1, 2'b00, 1'b0);
    tick();

    // R4 R6: shared write hit waits through foreign cycles
    expect_res(2'b10, 1'b1, "R4 shared write exclusive");
    send(1'b1, 2'b01, 1'b0);
    start_cyc(3'd4, 1'b0);
    beat(1, 0, 1);
    check(res_valid == 1'b0, "R6 io write no result", int'(res_valid), 0);
    check(req_ready == 1'b0, "R8 busy while waiting", int'(req_ready), 0);
    start_cyc(3'd2, 1'b0);
    beat(1, 0, 1);
    check(res_valid == 1'b0, "R6 writeback cycle no result", int'(res_valid), 0);
    start_cyc(3'd1, 1'b0);
    beat(1, 0, 1);
    tick();

    // R4: shared write, permit 0
    expect_res(2'b01, 1'b1, "R4 shared write stays shared");
    send(1'b1, 2'b01, 1'b0);
    start_cyc(3'd1, 1'b0);
    beat(1, 0, 0);
    tick();

    // R10: restart pulse during burst ignored
    expect_res(2'b10, 1'b0, "R10 restart ignored");
    send(1'b0, 2'b00, 1'b0);
    start_cyc(3'd0, 1'b1);
    beat(1, 0, 1);
    start_cyc(3'd3, 1'b0);
    beat(1, 0, 0); beat(1, 0, 0);
    check(res_valid == 1'b0, "R10 no early end", int'(res_valid), 0);
    beat(1, 0, 0);
    check(res_valid == 1'b1, "R10 burst completes", int'(res_valid), 1);
    tick();

    // R8: back-pressure holds the result
    res_ready = 1'b0;
    expect_res(2'b11, 1'b0, "R8 held result");
    send(1'b1, 2'b10, 1'b0);
    check(res_valid == 1'b1, "R8 valid held", int'(res_valid), 1);
    repeat (3) tick();
    check(res_valid == 1'b1 && res_state == 2'b11, "R8 stable", int'(res_state), 3);
    check(req_ready == 1'b0, "R8 no request while held", int'(req_ready), 0);
    res_ready = 1'b1;
    repeat (2) tick();
    check(res_valid == 1'b0, "R8 released", int'(res_valid), 0);

    check(exp_q.size() == 0, "all results seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule